// File: doc/BRIEF.md
# Streaming Address Generator with Programmable Delays

This block sequences the accesses of one memory bank that feeds, or is fed by, a register-file stream. A single configuration pulse loads the addressing mode, the transfer direction, a start address, a step, an access count, the bounds of a circular buffer, a bit-reverse length and three delay values, and then starts the stream. Each access appears at the ports as a one-cycle read or write strobe with its bank address.

The spacing of the accesses follows a three-part timing model. A start-up delay runs once after the stream is loaded. A gap delay runs before every access. A tail delay runs after the last access of a pass. A pass either ends the stream with a done pulse or repeats without end, starting again at the start address. Any of the three delays can be rewritten while the stream is running, so a controller can stretch or tighten the stream based on results it computes. A new value is used the next time its delay phase begins.

Top module: `stream_agu`

## Requirements
- R1: After reset the block is idle: busy, done, mem_rd and mem_wr are all low.
- R2: When cfg_load is sampled at clock edge E, the first strobe of the stream is high in the cycle that starts init+gap edges after E, using the init and gap values loaded with it. With both values zero, that is the cycle right after E. busy is high from that cycle onward.
- R3: Within a pass, consecutive strobes are 1+gap cycles apart. With every delay at zero, one access is issued on every clock.
- R4: With cfg_repeat=1, the first strobe of the next pass comes 1+tail+gap cycles after the last strobe of a pass. The address sequence restarts at the start address, and the start-up delay is not applied again.
- R5: Mode 0 (single) makes exactly one access per pass, at the start address, whatever the count.
- R6: Mode 1 (vector) makes count accesses per pass. Access i uses address base + i*step, modulo 2^AW.
- R7: Mode 2 (circular) makes count accesses per pass. Each address is the previous one plus step, minus (hi-lo+1) when that sum exceeds hi. As long as lo <= base <= hi and step <= hi-lo+1, every address stays within [lo, hi].
- R8: Mode 3 (bit-reversed) makes count accesses per pass. Access i uses address base + r, where r is the low L bits of i in reversed order and L is cfg_log2n.
- R9: When cfg_write=1, each access is a mem_wr strobe. Otherwise each access is a mem_rd strobe. The two strobes are never high together.
- R10: In a single-shot stream, done is high for one cycle, 1+tail cycles after the last strobe. busy drops in that same cycle. A repeating stream never raises done.
- R11: A pulse on dly_upd writes dly_val into the delay chosen by dly_sel (0 start-up, 1 gap, 2 tail; 3 is ignored). A countdown already running keeps its old length. The new value applies from the next time that phase begins.
- R12: When stop is high at an edge and cfg_load is not, the block goes idle at that edge. No further strobe is issued and done is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Loads every cfg_* field and starts the stream |
| cfg_mode | input | 2 | 0 single, 1 vector, 2 circular, 3 bit-reversed |
| cfg_write | input | 1 | 1 issues write strobes, 0 issues read strobes |
| cfg_repeat | input | 1 | 1 repeats the pass without end |
| cfg_base | input | AW | Start address |
| cfg_step | input | AW | Address step for vector and circular modes |
| cfg_count | input | CW | Accesses per pass |
| cfg_lo | input | AW | Lowest address of the circular buffer |
| cfg_hi | input | AW | Highest address of the circular buffer |
| cfg_log2n | input | LW | Number of index bits reversed in bit-reversed mode |
| cfg_init_dly | input | DW | Start-up delay in cycles |
| cfg_gap_dly | input | DW | Delay before each access in cycles |
| cfg_end_dly | input | DW | Delay after each pass in cycles |
| dly_upd | input | 1 | Runtime delay write strobe |
| dly_sel | input | 2 | Delay selected by dly_upd |
| dly_val | input | DW | New delay value |
| stop | input | 1 | Ends the stream and returns to idle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | AW | Bank address, valid while a strobe is high |
| busy | output | 1 | A stream is running |
| done | output | 1 | One-cycle pulse at the end of a single-shot stream |

## Verification
The stimulus table runs each addressing mode with a different delay setting. Zero delays expose an off-by-one in the gap and start-up counts. Non-zero delays separate the start-up, gap and tail phases from each other. A vector that wraps past the top of the address space and circular buffers whose sums step past the upper bound show whether the wrap arithmetic is right. Bit-reverse lengths of 3 and 4 catch a reversal over the wrong number of bits. Repeating rows show whether the address restarts between passes and whether the tail delay is placed there. Directed tests shrink the gap in the middle of a countdown, to show that the running count is kept and the new value is used afterwards, and stop a repeating stream to confirm that no strobe or done follows.

// File: rtl/sagu_pkg.sv
package sagu_pkg;

  typedef enum logic [1:0] {
    SAGU_SINGLE = 2'd0,
    SAGU_VECTOR = 2'd1,
    SAGU_CIRC   = 2'd2,
    SAGU_BITREV = 2'd3
  } sagu_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_INIT = 3'd1,
    PH_GAP  = 3'd2,
    PH_ACC  = 3'd3,
    PH_END  = 3'd4
  } sagu_phase_e;

  localparam int SAGU_NDLY = 3;  // start-up, gap, tail

endpackage

// File: rtl/sagu_dly_regs.sv
module sagu_dly_regs
  import sagu_pkg::*;
#(
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] init_in,
  input  logic [DW-1:0] gap_in,
  input  logic [DW-1:0] end_in,
  input  logic          upd,
  input  logic [1:0]    upd_sel,
  input  logic [DW-1:0] upd_val,
  output logic [DW-1:0] init_q,
  output logic [DW-1:0] gap_q,
  output logic [DW-1:0] end_q
);

  logic [DW-1:0] ld_val [SAGU_NDLY];
  logic [DW-1:0] dly_q  [SAGU_NDLY];

  assign ld_val[0] = init_in;
  assign ld_val[1] = gap_in;
  assign ld_val[2] = end_in;

  for (genvar k = 0; k < SAGU_NDLY; k++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dly_q[k] <= '0;
      else if (load)
        dly_q[k] <= ld_val[k];
      else if (upd && (upd_sel == 2'(k)))
        dly_q[k] <= upd_val;
    end
  end

  assign init_q = dly_q[0];
  assign gap_q  = dly_q[1];
  assign end_q  = dly_q[2];

endmodule

// File: rtl/sagu_seq.sv
module sagu_seq
  import sagu_pkg::*;
#(
  parameter int CW = 8,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  sagu_mode_e    mode,
  input  logic [CW-1:0] count,
  input  logic          repeat_en,
  input  logic [DW-1:0] init_d,
  input  logic [DW-1:0] gap_d,
  input  logic [DW-1:0] end_d,
  output logic          fire,
  output logic          pass_end,
  output logic          stream_fin,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] idx
);

  sagu_phase_e   phase_q, nxt_ph, g_ph, e_ph, i_ph;
  logic [DW-1:0] cnt_q, nxt_cnt, g_cnt, e_cnt, i_cnt;
  logic [CW-1:0] idx_q;
  logic          done_q, last, e_fin, fin;

  always_comb begin
    fire     = (phase_q == PH_ACC);
    last     = (mode == SAGU_SINGLE) ||
               (({1'b0, idx_q} + (CW+1)'(1)) >= {1'b0, count});
    pass_end = fire && last;

    // entering the gap phase: a zero gap goes straight to the access
    g_ph  = (gap_d == '0) ? PH_ACC : PH_GAP;
    g_cnt = gap_d;

    // entering the tail phase
    if (end_d != '0) begin
      e_ph = PH_END; e_cnt = end_d; e_fin = 1'b0;
    end else if (repeat_en) begin
      e_ph = g_ph; e_cnt = g_cnt; e_fin = 1'b0;
    end else begin
      e_ph = PH_IDLE; e_cnt = '0; e_fin = 1'b1;
    end

    // entering the start-up phase
    i_ph  = (init_d == '0) ? g_ph : PH_INIT;
    i_cnt = (init_d == '0) ? g_cnt : init_d;

    nxt_ph  = phase_q;
    nxt_cnt = (cnt_q != '0) ? cnt_q - DW'(1) : cnt_q;
    fin     = 1'b0;

    case (phase_q)
      PH_INIT: if (cnt_q <= DW'(1)) begin nxt_ph = g_ph; nxt_cnt = g_cnt; end
      PH_GAP:  if (cnt_q <= DW'(1)) begin nxt_ph = PH_ACC; nxt_cnt = '0; end
      PH_ACC: begin
        if (last) begin nxt_ph = e_ph; nxt_cnt = e_cnt; fin = e_fin; end
        else      begin nxt_ph = g_ph; nxt_cnt = g_cnt; end
      end
      PH_END: begin
        if (cnt_q <= DW'(1)) begin
          if (repeat_en) begin nxt_ph = g_ph; nxt_cnt = g_cnt; end
          else begin nxt_ph = PH_IDLE; nxt_cnt = '0; fin = 1'b1; end
        end
      end
      default: begin nxt_ph = PH_IDLE; nxt_cnt = '0; end
    endcase

    if (start) begin
      nxt_ph = i_ph; nxt_cnt = i_cnt; fin = 1'b0;
    end else if (stop) begin
      nxt_ph = PH_IDLE; nxt_cnt = '0; fin = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= nxt_ph;
      cnt_q   <= nxt_cnt;
      done_q  <= fin;
      if (start)     idx_q <= '0;
      else if (fire) idx_q <= last ? '0 : idx_q + CW'(1);
    end
  end

  assign stream_fin = fin;
  assign busy       = (phase_q != PH_IDLE);
  assign done       = done_q;
  assign idx        = idx_q;

endmodule

// File: rtl/sagu_addr.sv
module sagu_addr
  import sagu_pkg::*;
#(
  parameter int AW = 10,
  parameter int CW = 8,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_in,
  input  logic          fire,
  input  logic          pass_end,
  input  sagu_mode_e    mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [LW-1:0] log2n,
  input  logic [CW-1:0] idx,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] ptr_q, ptr_nxt, idx_w;

  // reverse the low n bits of v; bits at and above n are cleared
  function automatic logic [AW-1:0] bit_rev(input logic [AW-1:0] v,
                                            input logic [LW-1:0] n);
    int nn;
    logic [AW-1:0] r;
    nn = (int'(n) > AW) ? AW : int'(n);
    r  = '0;
    for (int k = 0; k < AW; k++)
      if (k < nn) r[k] = v[nn-1-k];
    return r;
  endfunction

  // one circular step: add, then fold back by the buffer length
  function automatic logic [AW-1:0] circ_next(input logic [AW-1:0] a,
                                              input logic [AW-1:0] st,
                                              input logic [AW-1:0] l,
                                              input logic [AW-1:0] h);
    logic [AW:0] s;
    s = {1'b0, a} + {1'b0, st};
    if (s > {1'b0, h})
      s = s - ({1'b0, h} - {1'b0, l} + (AW+1)'(1));
    return s[AW-1:0];
  endfunction

  always_comb begin
    case (mode)
      SAGU_VECTOR: ptr_nxt = ptr_q + step;
      SAGU_CIRC:   ptr_nxt = circ_next(ptr_q, step, lo, hi);
      default:     ptr_nxt = ptr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (start)
      ptr_q <= base_in;
    else if (fire)
      ptr_q <= pass_end ? base : ptr_nxt;
  end

  assign idx_w = AW'(idx);
  assign addr  = (mode == SAGU_BITREV) ? base + bit_rev(idx_w, log2n) : ptr_q;

endmodule

// File: rtl/stream_agu.sv
module stream_agu
  import sagu_pkg::*;
#(
  parameter int AW = 10,
  parameter int CW = 8,
  parameter int DW = 6,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_write,
  input  logic          cfg_repeat,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_step,
  input  logic [CW-1:0] cfg_count,
  input  logic [AW-1:0] cfg_lo,
  input  logic [AW-1:0] cfg_hi,
  input  logic [LW-1:0] cfg_log2n,
  input  logic [DW-1:0] cfg_init_dly,
  input  logic [DW-1:0] cfg_gap_dly,
  input  logic [DW-1:0] cfg_end_dly,
  input  logic          dly_upd,
  input  logic [1:0]    dly_sel,
  input  logic [DW-1:0] dly_val,
  input  logic          stop,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic          busy,
  output logic          done
);

  sagu_mode_e    mode_q;
  logic          wr_q, rep_q;
  logic [AW-1:0] base_q, step_q, lo_q, hi_q;
  logic [CW-1:0] count_q;
  logic [LW-1:0] log2n_q;

  logic [DW-1:0] dly_init_q, dly_gap_q, dly_end_q;
  logic [DW-1:0] init_eff, gap_eff, end_eff;

  // named internal events for the checker
  logic          fire, pass_end, stream_fin;
  logic [CW-1:0] idx;
  logic [AW-1:0] addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= SAGU_SINGLE;
      wr_q    <= 1'b0;
      rep_q   <= 1'b0;
      base_q  <= '0;
      step_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      count_q <= '0;
      log2n_q <= '0;
    end else if (cfg_load) begin
      mode_q  <= sagu_mode_e'(cfg_mode);
      wr_q    <= cfg_write;
      rep_q   <= cfg_repeat;
      base_q  <= cfg_base;
      step_q  <= cfg_step;
      lo_q    <= cfg_lo;
      hi_q    <= cfg_hi;
      count_q <= cfg_count;
      log2n_q <= cfg_log2n;
    end
  end

  sagu_dly_regs #(.DW(DW)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cfg_load),
    .init_in (cfg_init_dly),
    .gap_in  (cfg_gap_dly),
    .end_in  (cfg_end_dly),
    .upd     (dly_upd),
    .upd_sel (dly_sel),
    .upd_val (dly_val),
    .init_q  (dly_init_q),
    .gap_q   (dly_gap_q),
    .end_q   (dly_end_q)
  );

  // on the loading edge the phase entry must see the incoming values
  assign init_eff = cfg_load ? cfg_init_dly : dly_init_q;
  assign gap_eff  = cfg_load ? cfg_gap_dly  : dly_gap_q;
  assign end_eff  = cfg_load ? cfg_end_dly  : dly_end_q;

  sagu_seq #(.CW(CW), .DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (cfg_load),
    .stop       (stop),
    .mode       (mode_q),
    .count      (count_q),
    .repeat_en  (rep_q),
    .init_d     (init_eff),
    .gap_d      (gap_eff),
    .end_d      (end_eff),
    .fire       (fire),
    .pass_end   (pass_end),
    .stream_fin (stream_fin),
    .busy       (busy),
    .done       (done),
    .idx        (idx)
  );

  sagu_addr #(.AW(AW), .CW(CW), .LW(LW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cfg_load),
    .base_in  (cfg_base),
    .fire     (fire),
    .pass_end (pass_end),
    .mode     (mode_q),
    .base     (base_q),
    .step     (step_q),
    .lo       (lo_q),
    .hi       (hi_q),
    .log2n    (log2n_q),
    .idx      (idx),
    .addr     (addr)
  );

  assign mem_rd   = fire && !wr_q;
  assign mem_wr   = fire &&  wr_q;
  assign mem_addr = addr;

endmodule

// File: rtl/sagu_chk.sv
module sagu_chk #(
  parameter int AW = 10,
  parameter int DW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic          stop,
  input logic          fire,
  input logic          pass_end,
  input logic          stream_fin,
  input logic          busy,
  input logic          done,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mode,
  input logic [AW-1:0] lo,
  input logic [AW-1:0] hi,
  input logic [DW-1:0] gap_d,
  input logic          rep
);

  // R9
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R10
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> busy);

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R10
  done_single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rep);

  // R10
  fin_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stream_fin |=> done);

  // R7
  circ_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode == 2'd2) |-> (mem_addr >= lo && mem_addr <= hi));

  // R3
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !pass_end && gap_d == '0 && !stop && !cfg_load) |=> fire);

  // R2
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> busy);

  // R12
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !cfg_load) |=> (!busy && !done && !mem_rd && !mem_wr));

endmodule

bind stream_agu sagu_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load   (cfg_load),
  .stop       (stop),
  .fire       (fire),
  .pass_end   (pass_end),
  .stream_fin (stream_fin),
  .busy       (busy),
  .done       (done),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_addr   (mem_addr),
  .mode       (mode_q),
  .lo         (lo_q),
  .hi         (hi_q),
  .gap_d      (dly_gap_q),
  .rep        (rep_q)
);

// File: tb/stream_agu_test.sv
`timescale 1ns/1ps
module stream_agu_test;

  localparam int AW = 10, CW = 8, DW = 6, LW = 4;
  localparam int ASPAN = 1 << AW;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cfg_load = 0, cfg_write = 0, cfg_repeat = 0;
  logic [1:0]    cfg_mode = '0;
  logic [AW-1:0] cfg_base = '0, cfg_step = '0, cfg_lo = '0, cfg_hi = '0;
  logic [CW-1:0] cfg_count = '0;
  logic [LW-1:0] cfg_log2n = '0;
  logic [DW-1:0] cfg_init_dly = '0, cfg_gap_dly = '0, cfg_end_dly = '0;
  logic          dly_upd = 0, stop = 0;
  logic [1:0]    dly_sel = '0;
  logic [DW-1:0] dly_val = '0;
  logic          mem_rd, mem_wr, busy, done;
  logic [AW-1:0] mem_addr;

  stream_agu #(.AW(AW), .CW(CW), .DW(DW), .LW(LW)) uut (.*);

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, errors = 0;
  int cyc = 0;
  int ev_n = 0, done_n = 0, done_t = 0;
  int ev_t [256];
  int ev_a [256];
  int ev_w [256];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd || mem_wr) begin
        if (ev_n < 256) begin
          ev_t[ev_n] = cyc; ev_a[ev_n] = int'(mem_addr); ev_w[ev_n] = int'(mem_wr);
        end
        ev_n = ev_n + 1;
      end
      if (done) begin done_n = done_n + 1; done_t = cyc; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // columns: mode wr base step count lo hi log2n init gap tail repeat
  localparam int NV = 7;
  localparam int VEC [NV][12] = '{
    '{0, 0,   37, 0, 5,   0,   0, 0, 2, 1, 0, 0},  // R5 single, R2 start-up
    '{1, 1, 1020, 3, 4,   0,   0, 0, 0, 0, 0, 0},  // R6 wrap, R3 zero delays, R9 write
    '{2, 0,  100, 3, 6,  98, 104, 0, 1, 0, 0, 0},  // R7 circular
    '{3, 0,  200, 0, 8,   0,   0, 3, 0, 1, 2, 0},  // R8 L=3, R10 tail then done
    '{1, 0,   10, 1, 3,   0,   0, 0, 4, 1, 3, 1},  // R4 repeat with tail
    '{2, 1,   50, 2, 4,  48,  53, 0, 0, 0, 0, 1},  // R4 R7 repeat circular
    '{3, 1,    0, 0, 4,   0,   0, 4, 0, 2, 1, 0}   // R8 L=4
  };

  function automatic int exp_addr(input int m, input int b, input int s,
                                  input int lo, input int hi, input int l2, input int i);
    int r, x;
    case (m)
      1: return (b + i * s) % ASPAN;
      2: return lo + ((b - lo) + i * s) % (hi - lo + 1);
      3: begin
        r = 0; x = i;
        for (int k = 0; k < l2; k++) begin r = (r << 1) | (x & 1); x = x >> 1; end
        return (b + r) % ASPAN;
      end
      default: return b;
    endcase
  endfunction

  function automatic string mode_req(input int m);
    case (m)
      1: return "R6";
      2: return "R7";
      3: return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic launch(input int m, w, b, s, c, lo, hi, l2, ini, gp, en, rp,
                        output int t0);
    @(negedge clk); #1;
    ev_n = 0; done_n = 0;
    cfg_mode = 2'(m); cfg_write = w[0]; cfg_base = AW'(b); cfg_step = AW'(s);
    cfg_count = CW'(c); cfg_lo = AW'(lo); cfg_hi = AW'(hi); cfg_log2n = LW'(l2);
    cfg_init_dly = DW'(ini); cfg_gap_dly = DW'(gp); cfg_end_dly = DW'(en);
    cfg_repeat = rp[0]; cfg_load = 1'b1;
    t0 = cyc + 1;
    @(negedge clk); #1;
    cfg_load = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired R1..");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0, n, total, et, p, i;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_rd && !mem_wr, "R1 idle in reset", int'(busy), 0);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr, "R1 idle after reset", int'(busy), 0);

    for (int v = 0; v < NV; v++) begin
      launch(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5],
             VEC[v][6], VEC[v][7], VEC[v][8], VEC[v][9], VEC[v][10], VEC[v][11], t0);
      chk(busy == 1'b1, "R2 busy after load", int'(busy), 1);
      n = (VEC[v][0] == 0) ? 1 : VEC[v][4];
      total = VEC[v][11] ? 2 * n : n;
      for (int w = 0; w < 600; w++) begin
        if (VEC[v][11] ? (ev_n >= total) : (done_n > 0)) break;
        @(negedge clk); #1;
      end
      if (VEC[v][11]) begin
        stop = 1'b1; @(negedge clk); #1; stop = 1'b0;
      end
      repeat (6) @(negedge clk);
      #1;
      chk(ev_n == total, "R10 access count", ev_n, total);
      et = t0 + VEC[v][8] + VEC[v][9];
      for (int j = 0; j < total && j < ev_n; j++) begin
        p = j / n; i = j % n;
        if (j > 0) et = et + 1 + VEC[v][9] + ((i == 0) ? VEC[v][10] : 0);
        chk(ev_t[j] == et, (j == 0) ? "R2 first strobe time" :
                           (i == 0) ? "R4 pass restart time" : "R3 gap spacing",
            ev_t[j], et);
        chk(ev_a[j] == exp_addr(VEC[v][0], VEC[v][2], VEC[v][3], VEC[v][5],
                                VEC[v][6], VEC[v][7], i),
            (p > 0) ? "R4 restart address" : mode_req(VEC[v][0]), ev_a[j],
            exp_addr(VEC[v][0], VEC[v][2], VEC[v][3], VEC[v][5], VEC[v][6], VEC[v][7], i));
        chk(ev_w[j] == VEC[v][1], "R9 direction", ev_w[j], VEC[v][1]);
      end
      if (VEC[v][11]) begin
        chk(done_n == 0, "R10 no done when repeating", done_n, 0);
        chk(!busy, "R12 idle after stop", int'(busy), 0);
      end else begin
        chk(done_n == 1, "R10 one done pulse", done_n, 1);
        chk(done_t == et + 1 + VEC[v][10], "R10 done timing", done_t, et + 1 + VEC[v][10]);
        chk(!busy, "R10 busy low after done", int'(busy), 0);
      end
    end

    // R11 gap shrunk from 3 to 0 in the middle of the first countdown
    launch(1, 0, 0, 1, 4, 0, 0, 0, 0, 3, 0, 0, t0);
    for (int w = 0; w < 50 && ev_n < 1; w++) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    dly_upd = 1'b1; dly_sel = 2'd1; dly_val = '0;
    @(negedge clk); #1;
    dly_upd = 1'b0;
    repeat (10) @(negedge clk);
    #1;
    chk(ev_n == 4, "R11 access count", ev_n, 4);
    chk(ev_t[0] == t0 + 3, "R11 first access", ev_t[0], t0 + 3);
    chk(ev_t[1] == t0 + 7, "R11 running countdown kept", ev_t[1], t0 + 7);
    chk(ev_t[2] == t0 + 8, "R11 new gap applied", ev_t[2], t0 + 8);
    chk(ev_t[3] == t0 + 9, "R11 new gap applied", ev_t[3], t0 + 9);
    chk(done_t == t0 + 10, "R10 done after update", done_t, t0 + 10);

    // R11 select 3 is ignored: gap stays 2
    launch(1, 0, 5, 2, 2, 0, 0, 0, 0, 2, 0, 0, t0);
    @(negedge clk); #1;
    dly_upd = 1'b1; dly_sel = 2'd3; dly_val = DW'(0);
    @(negedge clk); #1;
    dly_upd = 1'b0;
    repeat (12) @(negedge clk);
    #1;
    chk(ev_n == 2 && ev_t[1] - ev_t[0] == 3, "R11 select 3 ignored",
        ev_t[1] - ev_t[0], 3);

    // R12 stop in the middle of a repeating back-to-back stream
    launch(1, 1, 0, 1, 4, 0, 0, 0, 0, 0, 0, 1, t0);
    for (int w = 0; w < 50 && ev_n < 3; w++) begin @(negedge clk); #1; end
    stop = 1'b1;
    @(negedge clk); #1;
    stop = 1'b0;
    chk(!busy, "R12 idle after stop", int'(busy), 0);
    repeat (10) @(negedge clk);
    #1;
    chk(ev_n == 3, "R12 no strobe after stop", ev_n, 3);
    chk(done_n == 0, "R12 no done after stop", done_n, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule